// File: doc/BRIEF.md
# Interrupt Pin Dispatcher

The dispatcher watches a bank of interrupt input pins and keeps one pending-request bit per pin. Each pin has a 64-bit redirection entry that comes from a table held in a separate register block. The entry sets how the pin is sensed (edge or level), whether the pin is masked, and what goes into the delivery message for that pin. A service pass starts when any pin rises or when the table owner pulses a "table written" strobe. During the pass the pins are visited in ascending index order. One message is sent for each pending, unmasked pin.

Messages leave the block on a valid/ready handshake, at most one per clock. While a message waits for `ready`, the scan stalls. A pin whose pending bit is set by a new trigger after the scan has already passed it is handled by a second pass that starts from pin 0 once the current pass ends. Edge pins lose their pending bit only when their message is accepted. Level pins follow their input, so every pass sends them again for as long as they stay high.

Top module: `irq_pin_dispatcher`

## Requirements
- R1: After a synchronous reset, `msg_valid` is 0 and every pending bit is 0. A table-written pulse with all pins low then produces no message.
- R2: For an edge pin (entry bit 15 = 0), a rising input sets the pending bit and exactly one message for that pin follows. A falling input before delivery does not cancel that message.
- R3: The pending bit of an edge pin is cleared only when its message is accepted (`msg_valid` and `msg_ready` high together). After that, a new pass sends nothing for that pin.
- R4: The pending bit of a level pin (entry bit 15 = 1) tracks the pin: high sets it, low clears it. Delivery does not clear it, so each later pass sends the pin again until the pin drops.
- R5: A pin whose entry has bit 16 set is skipped by the scan and keeps its pending bit. A later pass after the mask is cleared delivers it.
- R6: Within one pass, messages leave in ascending pin index order.
- R7: Message fields are taken from the entry as follows: destination = bits 63:56, logical destination mode = bit 11, delivery kind = bits 10:8, vector = bits 7:0, active-low polarity = bit 13, level trigger = bit 15. `msg_pin` carries the pin index.
- R8: When the delivery kind is 3'b111 (external interrupt), the message vector is 8'hFF whatever the entry's vector bits hold.
- R9: A pass starts only on a pin's rising input or on a `tbl_wr` pulse. A level pin held high causes no further messages without a new trigger.
- R10: While `msg_valid` is high and `msg_ready` is low, the message and `msg_valid` hold steady.
- R11: When a pin rises with no pass in progress, `msg_valid` for it is high after the second rising clock edge that samples the pin high, and not after the first.
- R12: A trigger that arrives while a pass is running causes another full pass from pin 0 when the current pass ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | NUM_PINS | Synchronous interrupt input pins |
| tbl_flat | input | NUM_PINS*64 | Redirection entries; pin i occupies bits i*64+63 : i*64 |
| tbl_wr | input | 1 | One-cycle pulse: the table was written, so start a pass |
| msg_ready | input | 1 | Receiver accepts the current message |
| msg_valid | output | 1 | A message is presented |
| msg_dest | output | 8 | Destination field |
| msg_logical | output | 1 | Logical destination mode |
| msg_kind | output | 3 | Delivery kind |
| msg_vector | output | 8 | Vector (8'hFF for external interrupt kind) |
| msg_active_low | output | 1 | Pin polarity, 1 = active low |
| msg_level | output | 1 | Trigger mode, 1 = level |
| msg_pin | output | PIN_W | Index of the pin the message belongs to |

## Verification
The case that is hardest to reach from the ports is a trigger that lands after the scan pointer has already moved past the triggering pin. Nothing is delivered for that pin until a restart pass runs. The stimulus sets up this case by raising a level pin with a higher index and holding `msg_ready` low so its message stalls. It then raises a lower-index edge pin. Once `msg_ready` is released, the expected order is high pin, low pin, high pin again. Masked pins that stay pending are shown by clearing the mask together with a `tbl_wr` pulse after the pin has already dropped.

// File: rtl/irqd_pkg.sv
package irqd_pkg;

    localparam int ENTRY_W = 64;
    localparam int DEST_W  = 8;
    localparam int VEC_W   = 8;
    localparam int KIND_W  = 3;

    localparam logic [KIND_W-1:0] KIND_EXTERNAL = 3'b111;
    localparam logic [VEC_W-1:0]  EXT_VECTOR    = 8'hFF;

    // Redirection entry, most significant field first
    typedef struct packed {
        logic [DEST_W-1:0] dest_id;      // 63:56
        logic [38:0]       resv;         // 55:17
        logic              masked;       // 16
        logic              level_trig;   // 15
        logic              remote_flag;  // 14
        logic              active_low;   // 13
        logic              busy;         // 12
        logic              logical_dst;  // 11
        logic [KIND_W-1:0] dlv_kind;     // 10:8
        logic [VEC_W-1:0]  vec;          // 7:0
    } redir_entry_t;

    typedef struct packed {
        logic [DEST_W-1:0] dest;
        logic              logical_dst;
        logic [KIND_W-1:0] dlv_kind;
        logic [VEC_W-1:0]  vector;
        logic              active_low;
        logic              level_trig;
    } irq_msg_t;

    function automatic irq_msg_t build_msg(input redir_entry_t e);
        irq_msg_t m;
        m.dest        = e.dest_id;
        m.logical_dst = e.logical_dst;
        m.dlv_kind    = e.dlv_kind;
        m.vector      = (e.dlv_kind == KIND_EXTERNAL) ? EXT_VECTOR : e.vec;
        m.active_low  = e.active_low;
        m.level_trig  = e.level_trig;
        return m;
    endfunction

endpackage

// File: rtl/irqd_pending.sv
module irqd_pending #(
    parameter int N = 24,
    localparam int PIN_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N-1:0]     pin_in,
    input  logic [N-1:0]     level_vec,
    input  logic             clr_en,
    input  logic [PIN_W-1:0] clr_idx,
    output logic [N-1:0]     pending,
    output logic             any_rise
);

    logic [N-1:0] pin_q;
    logic [N-1:0] rise;
    logic [N-1:0] pend_nxt;

    assign rise     = pin_in & ~pin_q;
    assign any_rise = |rise;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            if (level_vec[i]) begin
                pend_nxt[i] = pin_in[i];
            end else begin
                pend_nxt[i] = rise[i] |
                              (pending[i] & ~(clr_en && (clr_idx == PIN_W'(i))));
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pin_q   <= '0;
            pending <= '0;
        end else begin
            pin_q   <= pin_in;
            pending <= pend_nxt;
        end
    end

endmodule

// File: rtl/irqd_scan.sv
module irqd_scan #(
    parameter int N = 24,
    localparam int PIN_W = (N > 1) ? $clog2(N) : 1,
    localparam int PTR_W = PIN_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             trigger,
    input  logic             step_en,
    input  logic [N-1:0]     eligible,
    output logic             pick_valid,
    output logic [PIN_W-1:0] pick_idx
);

    logic             active;
    logic             restart;
    logic [PTR_W-1:0] ptr;
    logic [N-1:0]     window;
    logic             found;
    logic             pass_done;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            window[i] = eligible[i] && (PTR_W'(i) >= ptr);
        end
    end

    // Lowest eligible index at or above the pointer
    always_comb begin
        pick_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (window[i]) begin
                pick_idx = PIN_W'(i);
            end
        end
    end

    assign found      = |window;
    assign pick_valid = active && step_en && found;
    assign pass_done  = active && step_en && !found;

    always_ff @(posedge clk) begin
        if (rst) begin
            active  <= 1'b0;
            restart <= 1'b0;
            ptr     <= '0;
        end else if (!active) begin
            if (trigger) begin
                active <= 1'b1;
                ptr    <= '0;
            end
        end else if (pass_done) begin
            if (trigger || restart) begin
                ptr     <= '0;
                restart <= 1'b0;
            end else begin
                active  <= 1'b0;
            end
        end else begin
            if (pick_valid) begin
                ptr <= PTR_W'(pick_idx) + PTR_W'(1);
            end
            if (trigger) begin
                restart <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/irqd_msg_reg.sv
module irqd_msg_reg
    import irqd_pkg::*;
#(
    parameter int N = 24,
    localparam int PIN_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [PIN_W-1:0] load_idx,
    input  irq_msg_t         load_msg,
    input  logic             ready,
    output logic             valid,
    output irq_msg_t         msg,
    output logic [PIN_W-1:0] pin
);

    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            msg   <= '0;
            pin   <= '0;
        end else if (load) begin
            valid <= 1'b1;
            msg   <= load_msg;
            pin   <= load_idx;
        end else if (valid && ready) begin
            valid <= 1'b0;
        end
    end

endmodule

// File: rtl/irq_pin_dispatcher.sv
module irq_pin_dispatcher
    import irqd_pkg::*;
#(
    parameter int NUM_PINS = 24,
    localparam int PIN_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [NUM_PINS-1:0]          pin_in,
    input  logic [NUM_PINS*ENTRY_W-1:0]  tbl_flat,
    input  logic                         tbl_wr,
    input  logic                         msg_ready,
    output logic                         msg_valid,
    output logic [DEST_W-1:0]            msg_dest,
    output logic                         msg_logical,
    output logic [KIND_W-1:0]            msg_kind,
    output logic [VEC_W-1:0]             msg_vector,
    output logic                         msg_active_low,
    output logic                         msg_level,
    output logic [PIN_W-1:0]             msg_pin
);

    redir_entry_t        entries [NUM_PINS];
    logic [NUM_PINS-1:0] mask_vec;
    logic [NUM_PINS-1:0] level_vec;
    logic [NUM_PINS-1:0] pending_w;
    logic                any_rise;
    logic                trigger;
    logic                step_en;
    logic                deliver;
    logic                pick_valid;
    logic [PIN_W-1:0]    pick_idx;
    irq_msg_t            pick_msg;
    irq_msg_t            out_msg;

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_unpack
        assign entries[g]   = redir_entry_t'(tbl_flat[g*ENTRY_W +: ENTRY_W]);
        assign mask_vec[g]  = entries[g].masked;
        assign level_vec[g] = entries[g].level_trig;
    end

    assign trigger  = any_rise | tbl_wr;
    assign step_en  = !(msg_valid && !msg_ready);
    assign deliver  = msg_valid && msg_ready;
    assign pick_msg = build_msg(entries[pick_idx]);

    irqd_pending #(.N(NUM_PINS)) pend_i (
        .clk       (clk),
        .rst       (rst),
        .pin_in    (pin_in),
        .level_vec (level_vec),
        .clr_en    (deliver),
        .clr_idx   (msg_pin),
        .pending   (pending_w),
        .any_rise  (any_rise)
    );

    irqd_scan #(.N(NUM_PINS)) scan_i (
        .clk        (clk),
        .rst        (rst),
        .trigger    (trigger),
        .step_en    (step_en),
        .eligible   (pending_w & ~mask_vec),
        .pick_valid (pick_valid),
        .pick_idx   (pick_idx)
    );

    irqd_msg_reg #(.N(NUM_PINS)) out_i (
        .clk      (clk),
        .rst      (rst),
        .load     (pick_valid),
        .load_idx (pick_idx),
        .load_msg (pick_msg),
        .ready    (msg_ready),
        .valid    (msg_valid),
        .msg      (out_msg),
        .pin      (msg_pin)
    );

    assign msg_dest       = out_msg.dest;
    assign msg_logical    = out_msg.logical_dst;
    assign msg_kind       = out_msg.dlv_kind;
    assign msg_vector     = out_msg.vector;
    assign msg_active_low = out_msg.active_low;
    assign msg_level      = out_msg.level_trig;

endmodule

// File: rtl/irqd_checker.sv
module irqd_checker #(
    parameter int N = 24,
    localparam int PIN_W = (N > 1) ? $clog2(N) : 1
) (
    input logic             clk,
    input logic             rst,
    input logic [N-1:0]     pin_in,
    input logic [N-1:0]     level_vec,
    input logic [N-1:0]     pending,
    input logic             msg_valid,
    input logic             msg_ready,
    input logic [7:0]       msg_dest,
    input logic             msg_logical,
    input logic [2:0]       msg_kind,
    input logic [7:0]       msg_vector,
    input logic             msg_active_low,
    input logic             msg_level,
    input logic [PIN_W-1:0] msg_pin
);

    logic rst_d;

    always_ff @(posedge clk) begin
        rst_d <= rst;
        if (rst_d) begin
            AST_RESET_IDLE: assert (!msg_valid && pending == '0); // R1
        end
    end

    AST_HOLD_WHILE_STALLED: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && !msg_ready) |=> (msg_valid &&
            $stable({msg_dest, msg_logical, msg_kind, msg_vector,
                     msg_active_low, msg_level, msg_pin}))); // R10

    AST_EXT_VECTOR: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && msg_kind == 3'b111) |-> (msg_vector == 8'hFF)); // R8

    AST_EDGE_PENDING_KEPT: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && !msg_level) |-> pending[msg_pin]); // R3

    for (genvar i = 0; i < N; i++) begin : g_edge
        AST_EDGE_SET: assert property (@(posedge clk) disable iff (rst)
            (!level_vec[i] && pin_in[i] && !$past(pin_in[i])) |=> pending[i]); // R2
    end

endmodule

bind irq_pin_dispatcher irqd_checker #(.N(NUM_PINS)) chk_i (
    .clk            (clk),
    .rst            (rst),
    .pin_in         (pin_in),
    .level_vec      (level_vec),
    .pending        (pending_w),
    .msg_valid      (msg_valid),
    .msg_ready      (msg_ready),
    .msg_dest       (msg_dest),
    .msg_logical    (msg_logical),
    .msg_kind       (msg_kind),
    .msg_vector     (msg_vector),
    .msg_active_low (msg_active_low),
    .msg_level      (msg_level),
    .msg_pin        (msg_pin)
);

// File: tb/irq_pin_dispatcher_tb_top.sv
module irq_pin_dispatcher_tb_top;

    localparam int NP = 24;

    logic           clk = 1'b0;
    logic           rst;
    logic [NP-1:0]  pin_in;
    logic [63:0]    tbl [NP];
    logic [NP*64-1:0] tbl_flat;
    logic           tbl_wr;
    logic           msg_ready;
    logic           msg_valid;
    logic [7:0]     msg_dest;
    logic           msg_logical;
    logic [2:0]     msg_kind;
    logic [7:0]     msg_vector;
    logic           msg_active_low;
    logic           msg_level;
    logic [4:0]     msg_pin;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    int       got_pin [$];
    logic [7:0] got_vec [$];

    always #10 clk = ~clk;   // 50 MHz

    always_comb begin
        for (int i = 0; i < NP; i++) tbl_flat[i*64 +: 64] = tbl[i];
    end

    irq_pin_dispatcher #(.NUM_PINS(NP)) dut_i (
        .clk(clk), .rst(rst), .pin_in(pin_in), .tbl_flat(tbl_flat),
        .tbl_wr(tbl_wr), .msg_ready(msg_ready), .msg_valid(msg_valid),
        .msg_dest(msg_dest), .msg_logical(msg_logical), .msg_kind(msg_kind),
        .msg_vector(msg_vector), .msg_active_low(msg_active_low),
        .msg_level(msg_level), .msg_pin(msg_pin)
    );

    // Record accepted messages midway between the falling and rising edges
    always begin
        @(negedge clk);
        #5;
        if (msg_valid && msg_ready) begin
            got_pin.push_back(int'(msg_pin));
            got_vec.push_back(msg_vector);
        end
    end

    function automatic logic [63:0] mk(input logic [7:0] dest, input logic logical,
                                       input logic [2:0] kind, input logic [7:0] vec,
                                       input logic pol, input logic level, input logic mask);
        logic [63:0] e = '0;
        e[63:56] = dest; e[16] = mask; e[15] = level; e[13] = pol;
        e[11] = logical; e[10:8] = kind; e[7:0] = vec;
        return e;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_q();
        got_pin.delete();
        got_vec.delete();
    endtask

    task automatic pulse_wr();
        tbl_wr = 1'b1;
        cyc(1);
        tbl_wr = 1'b0;
    endtask

    task automatic t_reset();
        chk(msg_valid == 1'b0, "R1", "valid after reset", int'(msg_valid), 0);
        clear_q();
        pulse_wr();
        cyc(30);
        chk(got_pin.size() == 0, "R1", "messages with nothing pending", got_pin.size(), 0);
    endtask

    task automatic t_edge_basic();
        clear_q();
        tbl[4] = mk(8'h11, 0, 3'b000, 8'h40, 0, 0, 0);
        pin_in[4] = 1'b1;
        cyc(1);
        chk(msg_valid == 1'b0, "R11", "valid after first edge", int'(msg_valid), 0);
        cyc(1);
        chk(msg_valid == 1'b1 && msg_pin == 5'd4, "R11", "valid after second edge",
            int'(msg_valid), 1);
        cyc(10);
        chk(got_pin.size() == 1, "R2", "edge message count", got_pin.size(), 1);
        if (got_pin.size() == 1) begin
            chk(got_pin[0] == 4, "R2", "edge message pin", got_pin[0], 4);
            chk(got_vec[0] == 8'h40, "R2", "edge message vector", int'(got_vec[0]), 'h40);
        end
        pin_in[4] = 1'b0;
        cyc(2);
        pulse_wr();
        cyc(30);
        chk(got_pin.size() == 1, "R3", "edge pin after delivery", got_pin.size(), 1);
    endtask

    task automatic t_edge_hold();
        clear_q();
        msg_ready = 1'b0;
        tbl[6] = mk(8'h02, 0, 3'b000, 8'h66, 0, 0, 0);
        pin_in[6] = 1'b1;
        cyc(1);
        pin_in[6] = 1'b0;
        cyc(3);
        chk(msg_valid && msg_pin == 5'd6, "R10", "stalled message present", int'(msg_pin), 6);
        cyc(5);
        chk(msg_valid && msg_vector == 8'h66, "R10", "stalled message held",
            int'(msg_vector), 'h66);
        chk(got_pin.size() == 0, "R10", "no acceptance while not ready", got_pin.size(), 0);
        msg_ready = 1'b1;
        cyc(10);
        chk(got_pin.size() == 1 && got_pin[0] == 6, "R2", "delivered after falling input",
            got_pin.size(), 1);
        pulse_wr();
        cyc(30);
        chk(got_pin.size() == 1, "R3", "cleared after acceptance", got_pin.size(), 1);
    endtask

    task automatic t_level();
        clear_q();
        tbl[9] = mk(8'h09, 0, 3'b000, 8'h99, 0, 1, 0);
        pin_in[9] = 1'b1;
        cyc(20);
        chk(got_pin.size() == 1, "R9", "held level pin without trigger", got_pin.size(), 1);
        pulse_wr();
        cyc(20);
        chk(got_pin.size() == 2, "R4", "level pin redelivered", got_pin.size(), 2);
        if (got_pin.size() == 2)
            chk(got_pin[1] == 9, "R4", "redelivered pin", got_pin[1], 9);
        pin_in[9] = 1'b0;
        cyc(2);
        pulse_wr();
        cyc(20);
        chk(got_pin.size() == 2, "R4", "level pin after deassert", got_pin.size(), 2);
    endtask

    task automatic t_mask();
        clear_q();
        tbl[12] = mk(8'h0C, 0, 3'b000, 8'h52, 0, 0, 1);
        pin_in[12] = 1'b1;
        cyc(2);
        pin_in[12] = 1'b0;
        cyc(20);
        chk(got_pin.size() == 0, "R5", "masked pin skipped", got_pin.size(), 0);
        tbl[12] = mk(8'h0C, 0, 3'b000, 8'h52, 0, 0, 0);
        pulse_wr();
        cyc(20);
        chk(got_pin.size() == 1 && got_pin[0] == 12, "R5", "kept pending then delivered",
            got_pin.size(), 1);
        chk(got_pin.size() == 1, "R9", "table write starts a pass", got_pin.size(), 1);
    endtask

    task automatic t_order();
        clear_q();
        tbl[2]  = mk(8'h01, 0, 3'b000, 8'h82, 0, 0, 0);
        tbl[15] = mk(8'h01, 0, 3'b000, 8'h8F, 0, 0, 0);
        tbl[20] = mk(8'h01, 0, 3'b000, 8'h94, 0, 0, 0);
        pin_in[20] = 1'b1; pin_in[2] = 1'b1; pin_in[15] = 1'b1;
        cyc(2);
        pin_in[20] = 1'b0; pin_in[2] = 1'b0; pin_in[15] = 1'b0;
        cyc(20);
        chk(got_pin.size() == 3, "R6", "message count", got_pin.size(), 3);
        if (got_pin.size() == 3) begin
            chk(got_pin[0] == 2,  "R6", "first pin",  got_pin[0], 2);
            chk(got_pin[1] == 15, "R6", "second pin", got_pin[1], 15);
            chk(got_pin[2] == 20, "R6", "third pin",  got_pin[2], 20);
        end
    endtask

    task automatic t_fields();
        clear_q();
        msg_ready = 1'b0;
        tbl[7] = mk(8'hA5, 1, 3'b001, 8'h3C, 1, 1, 0);
        pin_in[7] = 1'b1;
        cyc(4);
        chk(msg_valid == 1'b1, "R7", "valid", int'(msg_valid), 1);
        chk(msg_dest == 8'hA5, "R7", "destination", int'(msg_dest), 'hA5);
        chk(msg_logical == 1'b1, "R7", "dest mode", int'(msg_logical), 1);
        chk(msg_kind == 3'b001, "R7", "delivery kind", int'(msg_kind), 1);
        chk(msg_vector == 8'h3C, "R7", "vector", int'(msg_vector), 'h3C);
        chk(msg_active_low == 1'b1, "R7", "polarity", int'(msg_active_low), 1);
        chk(msg_level == 1'b1, "R7", "trigger mode", int'(msg_level), 1);
        chk(msg_pin == 5'd7, "R7", "pin index", int'(msg_pin), 7);
        msg_ready = 1'b1;
        cyc(5);
        pin_in[7] = 1'b0;
        cyc(5);
    endtask

    task automatic t_extint();
        clear_q();
        msg_ready = 1'b0;
        tbl[10] = mk(8'h01, 0, 3'b111, 8'h22, 0, 0, 0);
        pin_in[10] = 1'b1;
        cyc(3);
        chk(msg_valid && msg_vector == 8'hFF, "R8", "external vector", int'(msg_vector), 'hFF);
        chk(msg_kind == 3'b111, "R8", "external kind", int'(msg_kind), 7);
        msg_ready = 1'b1;
        cyc(5);
        pin_in[10] = 1'b0;
        cyc(5);
        chk(got_vec.size() == 1 && got_vec[0] == 8'hFF, "R8", "accepted vector",
            got_vec.size(), 1);
    endtask

    task automatic t_restart();
        clear_q();
        msg_ready = 1'b0;
        tbl[3] = mk(8'h03, 0, 3'b000, 8'h33, 0, 1, 0);
        tbl[1] = mk(8'h03, 0, 3'b000, 8'h31, 0, 0, 0);
        pin_in[3] = 1'b1;
        cyc(3);
        pin_in[1] = 1'b1;
        cyc(3);
        msg_ready = 1'b1;
        cyc(20);
        chk(got_pin.size() == 3, "R12", "restart message count", got_pin.size(), 3);
        if (got_pin.size() == 3) begin
            chk(got_pin[0] == 3, "R12", "first", got_pin[0], 3);
            chk(got_pin[1] == 1, "R12", "second", got_pin[1], 1);
            chk(got_pin[2] == 3, "R12", "third", got_pin[2], 3);
        end
        pin_in[1] = 1'b0;
        pin_in[3] = 1'b0;
        cyc(5);
    endtask

    initial begin
        rst = 1'b1; pin_in = '0; tbl_wr = 1'b0; msg_ready = 1'b1;
        for (int i = 0; i < NP; i++) tbl[i] = mk(8'h00, 0, 3'b000, 8'h30, 0, 0, 0);
        cyc(3);
        rst = 1'b0;
        cyc(1);
        t_reset();
        t_edge_basic();
        t_edge_hold();
        t_level();
        t_mask();
        t_order();
        t_fields();
        t_extint();
        t_restart();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule